// File: doc/BRIEF.md
# Pointer-Addressed I2C Register Slave

This block is a two-wire serial slave that exposes a small register bank through an internal 2-bit pointer. The bus lines are oversampled by the system clock, and the block pulls the data line low through an open-drain enable. The bank holds a read-only 12-bit temperature word, which the sensor side loads through a port with a strobe. It also holds a configuration byte and two 12-bit limit words, which the conversion and alert logic use.

A master first writes the pointer byte. Any bytes after it in the same write transfer update the selected register. A read transfer returns the selected register with no pointer byte, so repeated reads of one register cost only an address byte each. General-call commands can re-latch the address-select pins or return the whole bank to its reset values. A high-speed master code is recognised, left unacknowledged, and flagged until the next STOP.

Top module: `i2c_reg_slave`

## Requirements
- R1: After reset the pointer is 0, the temperature word is 0x000, the low limit is 0x4B0, the high limit is 0x500 and the stored configuration bits are 0. A configuration read returns 0x80 because its bit 7 (the comparator status flag) resets to 1.
- R2: The slave answers only to the 7-bit address {1001, pins}, where the three pin bits are latched once after reset. Changing the pins later has no effect until a re-latch, and any other address is not acknowledged.
- R3: In a write transfer the first data byte sets the pointer from its two LSBs: 00 selects temperature, 01 configuration, 10 low limit and 11 high limit. Every byte is acknowledged. Writes that select temperature are acknowledged but change nothing.
- R4: A read transfer returns the register chosen by the most recently written pointer, and the pointer stays valid across any number of read transfers.
- R5: A 12-bit word is sent and received as two bytes, MSB first. The first byte carries bits [11:4]. The second byte carries bits [3:0] in its upper nibble; its lower nibble reads as zero and is ignored on writes. Further bytes in the same transfer alternate between the two halves.
- R6: A configuration write stores bits [6:0] and pulses cfg_wr_o for one cycle with the full written byte on cfg_wdata_o. A configuration read returns {status flag, stored bits}, and the status flag is loaded from os_flag_i when os_upd_i is high.
- R7: When temp_vld_i is high, the temperature word is loaded from temp_i.
- R8: A general call (address byte 0x00) is acknowledged. A second byte of 0x04 re-latches the address pins only. A second byte of 0x06 re-latches the pins and returns every register and the pointer to the R1 values.
- R9: A first byte after START of the form 00001xxx is not acknowledged and sets hs_mode_o. The flag stays set through repeated STARTs and clears on STOP.
- R10: When the master answers a read byte with NACK, the slave stops driving SDA and sends nothing more.
- R11: A STOP at any point releases SDA and returns the slave to idle. A START at any point, including inside a byte, drops the transfer in progress and begins a new address byte.
- R12: Each addressed read transfer produces exactly one single-cycle pulse on rd_stb_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, several times faster than SCL |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | High pulls SDA low |
| addr_pins_i | input | 3 | Address-select pin levels |
| temp_i | input | 12 | Conversion result |
| temp_vld_i | input | 1 | Load strobe for temp_i |
| os_flag_i | input | 1 | Comparator status from the alert logic |
| os_upd_i | input | 1 | Load strobe for os_flag_i |
| hs_mode_o | output | 1 | High-speed master code seen, until STOP |
| rd_stb_o | output | 1 | One-cycle pulse per read transfer |
| cfg_wr_o | output | 1 | One-cycle pulse on a configuration write |
| cfg_wdata_o | output | 8 | Byte written to configuration |
| cfg_o | output | 7 | Stored configuration bits [6:0] |
| tlow_o | output | 12 | Low limit word |
| thigh_o | output | 12 | High limit word |

## Verification
The hardest situations to reach from the pins are bus conditions that arrive where a well-behaved master never puts them: a STOP or a repeated START a few bits into an address byte, and the high-speed code followed by a repeated START. The bench drives these through a bit-level master that can cut a byte after any number of bits and then checks that the next full transfer still returns correct data. The address re-latch needs the pins to change while the slave ignores them, so the bench moves the pins, shows the new address is refused, and only then issues the general-call commands.

// File: rtl/i2c_reg_pkg.sv
package i2c_reg_pkg;
  localparam logic [1:0] SEL_TEMP = 2'b00;
  localparam logic [1:0] SEL_CFG  = 2'b01;
  localparam logic [1:0] SEL_TLO  = 2'b10;
  localparam logic [1:0] SEL_THI  = 2'b11;

  localparam logic [7:0] GC_ADDR_BYTE = 8'h00;
  localparam logic [7:0] GC_RELATCH   = 8'h04;
  localparam logic [7:0] GC_RESET     = 8'h06;
  localparam logic [4:0] HS_CODE_TOP  = 5'b00001;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_ACKW, ST_ACK, ST_TX, ST_MACK, ST_LOAD
  } bus_st_e;

  typedef enum logic [2:0] {
    MD_ADDR, MD_PTR, MD_DATA, MD_GC, MD_DONE
  } xfer_md_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic start_o,
  output logic stop_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[STAGES-2:0], sda_i};
      scl_q  <= scl_sh[STAGES-1];
      sda_q  <= sda_sh[STAGES-1];
    end
  end

  assign scl_o   = scl_sh[STAGES-1];
  assign sda_o   = sda_sh[STAGES-1];
  assign start_o = scl_o & scl_q & sda_q & ~sda_o;
  assign stop_o  = scl_o & scl_q & ~sda_q & sda_o;
  assign rise_o  = scl_o & ~scl_q;
  assign fall_o  = ~scl_o & scl_q;
endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank import i2c_reg_pkg::*; #(
  parameter int DATA_W = 12,
  parameter logic [DATA_W-1:0] TLOW_RST  = 12'h4B0,
  parameter logic [DATA_W-1:0] THIGH_RST = 12'h500
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              gc_rst_i,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic              wr_hi_i,
  input  logic [7:0]        wr_byte_i,
  input  logic [1:0]        rd_sel_i,
  input  logic              rd_hi_i,
  output logic [7:0]        rd_byte_o,
  input  logic [DATA_W-1:0] temp_i,
  input  logic              temp_vld_i,
  input  logic              os_flag_i,
  input  logic              os_upd_i,
  output logic [6:0]        cfg_o,
  output logic              cfg_wr_o,
  output logic [7:0]        cfg_wdata_o,
  output logic [DATA_W-1:0] tlow_o,
  output logic [DATA_W-1:0] thigh_o
);
  localparam int LO_W = DATA_W - 8;

  logic [DATA_W-1:0] temp_q, rd_word;
  logic [6:0]        cfg_q;
  logic              os_q;

  function automatic logic [DATA_W-1:0] merge_half(input logic [DATA_W-1:0] old,
                                                   input logic hi, input logic [7:0] b);
    if (hi) merge_half = {b, old[LO_W-1:0]};
    else    merge_half = {old[DATA_W-1:LO_W], b[7 -: LO_W]};
  endfunction

  for (genvar g = 0; g < 2; g++) begin : g_lim
    localparam logic [DATA_W-1:0] RST_VAL = (g == 0) ? TLOW_RST : THIGH_RST;
    localparam logic [1:0]        MY_SEL  = (g == 0) ? SEL_TLO : SEL_THI;
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             q <= RST_VAL;
      else if (gc_rst_i)                       q <= RST_VAL;
      else if (wr_en_i && wr_sel_i == MY_SEL)  q <= merge_half(q, wr_hi_i, wr_byte_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      temp_q      <= '0;
      cfg_q       <= '0;
      os_q        <= 1'b1;
      cfg_wr_o    <= 1'b0;
      cfg_wdata_o <= '0;
    end else begin
      cfg_wr_o <= 1'b0;
      if (gc_rst_i) begin
        temp_q <= '0;
        cfg_q  <= '0;
        os_q   <= 1'b1;
      end else begin
        if (temp_vld_i) temp_q <= temp_i;
        if (os_upd_i)   os_q   <= os_flag_i;
        if (wr_en_i && wr_sel_i == SEL_CFG) begin
          cfg_q       <= wr_byte_i[6:0];
          cfg_wr_o    <= 1'b1;
          cfg_wdata_o <= wr_byte_i;
        end
      end
    end
  end

  always_comb begin
    unique case (rd_sel_i)
      SEL_TLO: rd_word = g_lim[0].q;
      SEL_THI: rd_word = g_lim[1].q;
      default: rd_word = temp_q;
    endcase
    if (rd_sel_i == SEL_CFG) rd_byte_o = {os_q, cfg_q};
    else if (rd_hi_i)        rd_byte_o = rd_word[DATA_W-1 -: 8];
    else                     rd_byte_o = 8'(rd_word[LO_W-1:0]) << (8 - LO_W);
  end

  assign cfg_o   = cfg_q;
  assign tlow_o  = g_lim[0].q;
  assign thigh_o = g_lim[1].q;
endmodule

// File: rtl/i2c_slave_ctrl.sv
module i2c_slave_ctrl import i2c_reg_pkg::*; #(
  parameter int PIN_W = 3,
  parameter logic [6-PIN_W:0] ADDR_BASE = 4'b1001
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sda_s_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             rise_i,
  input  logic             fall_i,
  input  logic [PIN_W-1:0] addr_pins_i,
  input  logic [7:0]       rd_byte_i,
  output logic             sda_oe_o,
  output logic             hs_mode_o,
  output logic             rd_stb_o,
  output logic             wr_en_o,
  output logic             wr_hi_o,
  output logic [7:0]       wr_byte_o,
  output logic [1:0]       ptr_o,
  output logic             hi_o,
  output logic             gc_rst_o
);
  bus_st_e          st_q;
  xfer_md_e         md_q;
  logic [2:0]       cnt_q;
  logic [7:0]       sh_q;
  logic             first_q, ack_q, rd_q, lo_q, latch_q;
  logic [PIN_W-1:0] pins_q;
  logic [7:0]       rx_byte;

  assign rx_byte = {sh_q[6:0], sda_s_i};
  assign hi_o    = ~lo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE;  md_q <= MD_ADDR;  cnt_q <= '0;  sh_q <= '0;
      first_q <= 1'b0;  ack_q <= 1'b0;  rd_q <= 1'b0;  lo_q <= 1'b0;
      latch_q <= 1'b1;  pins_q <= '0;  ptr_o <= SEL_TEMP;
      sda_oe_o <= 1'b0; hs_mode_o <= 1'b0; rd_stb_o <= 1'b0;
      wr_en_o <= 1'b0;  wr_hi_o <= 1'b0; wr_byte_o <= '0; gc_rst_o <= 1'b0;
    end else begin
      rd_stb_o <= 1'b0;
      wr_en_o  <= 1'b0;
      gc_rst_o <= 1'b0;
      if (latch_q) begin
        pins_q  <= addr_pins_i;
        latch_q <= 1'b0;
      end
      if (stop_i) begin
        st_q      <= ST_IDLE;
        sda_oe_o  <= 1'b0;
        hs_mode_o <= 1'b0;
      end else if (start_i) begin
        st_q     <= ST_RX;
        md_q     <= MD_ADDR;
        cnt_q    <= '0;
        first_q  <= 1'b1;
        rd_q     <= 1'b0;
        sda_oe_o <= 1'b0;
      end else begin
        unique case (st_q)
          ST_RX: if (rise_i) begin
            sh_q  <= rx_byte;
            cnt_q <= cnt_q + 3'd1;
            if (cnt_q == 3'd7) begin
              st_q    <= ST_ACKW;
              first_q <= 1'b0;
              ack_q   <= 1'b1;
              unique case (md_q)
                MD_ADDR: begin
                  lo_q <= 1'b0;
                  if (first_q && rx_byte[7:3] == HS_CODE_TOP) begin
                    hs_mode_o <= 1'b1;
                    ack_q     <= 1'b0;
                  end else if (rx_byte[7:1] == {ADDR_BASE, pins_q}) begin
                    rd_q     <= rx_byte[0];
                    rd_stb_o <= rx_byte[0];
                    md_q     <= rx_byte[0] ? MD_DONE : MD_PTR;
                  end else if (rx_byte == GC_ADDR_BYTE) begin
                    md_q <= MD_GC;
                  end else begin
                    ack_q <= 1'b0;
                  end
                end
                MD_PTR: begin
                  ptr_o <= rx_byte[1:0];
                  md_q  <= MD_DATA;
                end
                MD_DATA: begin
                  wr_en_o   <= 1'b1;
                  wr_hi_o   <= ~lo_q;
                  wr_byte_o <= rx_byte;
                  lo_q      <= ~lo_q;
                end
                MD_GC: begin
                  md_q <= MD_DONE;
                  if (rx_byte == GC_RELATCH || rx_byte == GC_RESET) latch_q <= 1'b1;
                  else ack_q <= 1'b0;
                  if (rx_byte == GC_RESET) begin
                    gc_rst_o <= 1'b1;
                    ptr_o    <= SEL_TEMP;
                  end
                end
                default: ack_q <= 1'b0;
              endcase
            end
          end
          ST_ACKW: if (fall_i) begin
            sda_oe_o <= ack_q;
            st_q     <= ack_q ? ST_ACK : ST_IDLE;
          end
          ST_ACK, ST_LOAD: if (fall_i) begin
            cnt_q <= '0;
            if (rd_q || st_q == ST_LOAD) begin
              sh_q     <= {rd_byte_i[6:0], 1'b0};
              sda_oe_o <= ~rd_byte_i[7];
              lo_q     <= ~lo_q;
              st_q     <= ST_TX;
            end else begin
              sda_oe_o <= 1'b0;
              st_q     <= ST_RX;
            end
          end
          ST_TX: if (fall_i) begin
            if (cnt_q == 3'd7) begin
              sda_oe_o <= 1'b0;
              st_q     <= ST_MACK;
            end else begin
              sda_oe_o <= ~sh_q[7];
              sh_q     <= {sh_q[6:0], 1'b0};
              cnt_q    <= cnt_q + 3'd1;
            end
          end
          ST_MACK: if (rise_i) st_q <= sda_s_i ? ST_IDLE : ST_LOAD;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave import i2c_reg_pkg::*; #(
  parameter int DATA_W      = 12,
  parameter int PIN_W       = 3,
  parameter int SYNC_STAGES = 2,
  parameter logic [6-PIN_W:0]  ADDR_BASE = 4'b1001,
  parameter logic [DATA_W-1:0] TLOW_RST  = 12'h4B0,
  parameter logic [DATA_W-1:0] THIGH_RST = 12'h500
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic [PIN_W-1:0]  addr_pins_i,
  input  logic [DATA_W-1:0] temp_i,
  input  logic              temp_vld_i,
  input  logic              os_flag_i,
  input  logic              os_upd_i,
  output logic              hs_mode_o,
  output logic              rd_stb_o,
  output logic              cfg_wr_o,
  output logic [7:0]        cfg_wdata_o,
  output logic [6:0]        cfg_o,
  output logic [DATA_W-1:0] tlow_o,
  output logic [DATA_W-1:0] thigh_o
);
  logic scl_s, sda_s, start_evt, stop_evt, rise_evt, fall_evt;
  logic wr_en, wr_hi, hi_sel, gc_rst;
  logic [7:0] wr_byte, rd_byte;
  logic [1:0] ptr;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .start_o(start_evt), .stop_o(stop_evt),
    .rise_o(rise_evt), .fall_o(fall_evt)
  );

  i2c_slave_ctrl #(.PIN_W(PIN_W), .ADDR_BASE(ADDR_BASE)) u_ctrl (
    .clk_i, .rst_ni, .sda_s_i(sda_s), .start_i(start_evt), .stop_i(stop_evt),
    .rise_i(rise_evt), .fall_i(fall_evt), .addr_pins_i, .rd_byte_i(rd_byte),
    .sda_oe_o, .hs_mode_o, .rd_stb_o, .wr_en_o(wr_en), .wr_hi_o(wr_hi),
    .wr_byte_o(wr_byte), .ptr_o(ptr), .hi_o(hi_sel), .gc_rst_o(gc_rst)
  );

  i2c_reg_bank #(.DATA_W(DATA_W), .TLOW_RST(TLOW_RST), .THIGH_RST(THIGH_RST)) u_bank (
    .clk_i, .rst_ni, .gc_rst_i(gc_rst), .wr_en_i(wr_en), .wr_sel_i(ptr),
    .wr_hi_i(wr_hi), .wr_byte_i(wr_byte), .rd_sel_i(ptr), .rd_hi_i(hi_sel),
    .rd_byte_o(rd_byte), .temp_i, .temp_vld_i, .os_flag_i, .os_upd_i,
    .cfg_o, .cfg_wr_o, .cfg_wdata_o, .tlow_o, .thigh_o
  );
endmodule

// File: rtl/i2c_reg_slave_chk.sv
module i2c_reg_slave_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_s,
  input logic stop_evt,
  input logic sda_oe_o,
  input logic hs_mode_o,
  input logic rd_stb_o,
  input logic cfg_wr_o
);
  assert_rd_stb_single_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_stb_o |=> !rd_stb_o);

  assert_cfg_stb_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_wr_o |=> !cfg_wr_o);

  assert_hs_clear_on_stop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_evt |=> !hs_mode_o);

  assert_release_on_stop_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_evt |=> !sda_oe_o);

  assert_drive_in_low_phase_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> !scl_s);
endmodule

bind i2c_reg_slave i2c_reg_slave_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_s(scl_s), .stop_evt(stop_evt),
  .sda_oe_o(sda_oe_o), .hs_mode_o(hs_mode_o), .rd_stb_o(rd_stb_o), .cfg_wr_o(cfg_wr_o)
);

// File: tb/tb_i2c_reg_slave.sv
`timescale 1ns/1ps
module tb_i2c_reg_slave;
  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [2:0] pins = 3'b010;
  logic [11:0] temp_in = '0;
  logic temp_vld = 1'b0, os_flag = 1'b1, os_upd = 1'b0;
  logic sda_oe, hs_mode, rd_stb, cfg_wr;
  logic [7:0] cfg_wdata;
  logic [6:0] cfg;
  logic [11:0] tlow, thigh;
  wire sda_line = sda_m & ~sda_oe;

  int n_chk = 0, n_fail = 0, rd_pulses = 0, cfg_pulses = 0;
  logic [7:0] last_cfg_wdata = '0;

  always #2 clk = ~clk;

  i2c_reg_slave dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .addr_pins_i(pins), .temp_i(temp_in), .temp_vld_i(temp_vld), .os_flag_i(os_flag),
    .os_upd_i(os_upd), .hs_mode_o(hs_mode), .rd_stb_o(rd_stb), .cfg_wr_o(cfg_wr),
    .cfg_wdata_o(cfg_wdata), .cfg_o(cfg), .tlow_o(tlow), .thigh_o(thigh)
  );

  always @(posedge clk) begin
    if (rd_stb) rd_pulses++;
    if (cfg_wr) begin
      cfg_pulses++;
      last_cfg_wdata = cfg_wdata;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic qw();
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; qw(); scl_m = 1'b1; qw(); sda_m = 1'b0; qw(); scl_m = 1'b0; qw();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; qw(); scl_m = 1'b1; qw(); sda_m = 1'b1; qw();
  endtask

  task automatic bus_bit(input logic b, output logic s);
    sda_m = b; qw(); scl_m = 1'b1; qw(); s = sda_line; qw(); scl_m = 1'b0; qw();
  endtask

  task automatic wbyte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bus_bit(b[i], s);
    bus_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic rbyte(input logic nack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bus_bit(1'b1, s);
      b[i] = s;
    end
    bus_bit(nack, s);
  endtask

  logic [6:0] cur_addr;

  task automatic set_ptr(input logic [1:0] p);
    logic a;
    bus_start();
    wbyte({cur_addr, 1'b0}, a); chk("R2 addr ack", a, 1);
    wbyte({6'd0, p}, a);        chk("R3 ptr ack", a, 1);
    bus_stop();
  endtask

  task automatic wr_word(input logic [1:0] p, input logic [7:0] b0, input logic [7:0] b1);
    logic a;
    bus_start();
    wbyte({cur_addr, 1'b0}, a); chk("R2 addr ack", a, 1);
    wbyte({6'd0, p}, a);        chk("R3 ptr ack", a, 1);
    wbyte(b0, a);               chk("R3 data ack", a, 1);
    wbyte(b1, a);               chk("R3 data ack", a, 1);
    bus_stop();
  endtask

  task automatic rd_word(output logic [7:0] b0, output logic [7:0] b1);
    logic a;
    bus_start();
    wbyte({cur_addr, 1'b1}, a); chk("R2 read addr ack", a, 1);
    rbyte(1'b0, b0);
    rbyte(1'b1, b1);
    bus_stop();
  endtask

  initial begin
    logic [7:0] h, l, x, y;
    logic a;
    logic [11:0] v;
    logic [7:0] c;
    int p0;
    fork
      begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
      end
    join_none
    cur_addr = {4'b1001, 3'b010};
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    qw();
    // R1 reset state
    chk("R1 sda released", sda_oe, 0);
    chk("R9 hs flag at reset", hs_mode, 0);
    chk("R1 tlow reset", tlow, 12'h4B0);
    chk("R1 thigh reset", thigh, 12'h500);
    chk("R1 cfg reset", cfg, 0);
    rd_word(h, l); chk("R1 temp reset", {h, l}, 16'h0000);
    set_ptr(2'b01);
    bus_start(); wbyte({cur_addr, 1'b1}, a); rbyte(1'b1, h); bus_stop();
    chk("R1 cfg read 0x80", h, 8'h80);
    set_ptr(2'b10); rd_word(h, l); chk("R1 tlow read", {h, l}, 16'h4B00);
    set_ptr(2'b11); rd_word(h, l); chk("R1 thigh read", {h, l}, 16'h5000);

    // R3 R4 R5 low-limit sweep
    for (int i = 0; i < 32; i++) begin
      v = 12'((i * 131 + 7) & 12'hFFF);
      wr_word(2'b10, v[11:4], {v[3:0], 4'h0});
      chk("R3 tlow written", tlow, v);
      rd_word(h, l);
      chk("R5 tlow two-byte read", {h, l}, {v, 4'h0});
    end
    // R5 high-limit sweep, low nibble of second byte ignored
    for (int i = 0; i < 32; i++) begin
      v = 12'((i * 397 + 3) & 12'hFFF);
      wr_word(2'b11, v[11:4], {v[3:0], 4'hF});
      chk("R5 thigh lower nibble ignored", thigh, v);
      rd_word(h, l);
      chk("R5 thigh two-byte read", {h, l}, {v, 4'h0});
    end
    // R4 repeated reads, R5 alternating halves, R12 one strobe
    p0 = rd_pulses;
    bus_start(); wbyte({cur_addr, 1'b1}, a);
    rbyte(1'b0, h); rbyte(1'b0, l); rbyte(1'b0, x); rbyte(1'b1, y); bus_stop();
    chk("R5 alternating halves", {h, l, x, y}, {v, 4'h0, v, 4'h0});
    chk("R12 one strobe per read", rd_pulses - p0, 1);
    rd_word(h, l); chk("R4 pointer kept", {h, l}, {v, 4'h0});

    // R6 configuration sweep
    os_flag = 1'b1;
    for (int i = 0; i < 32; i++) begin
      c = 8'((i * 37 + 1) & 8'hFF);
      p0 = cfg_pulses;
      bus_start(); wbyte({cur_addr, 1'b0}, a); wbyte(8'h01, a); wbyte(c, a);
      chk("R6 cfg data ack", a, 1); bus_stop();
      chk("R6 one cfg strobe", cfg_pulses - p0, 1);
      chk("R6 strobe data", last_cfg_wdata, c);
      chk("R6 cfg stored", cfg, c[6:0]);
      bus_start(); wbyte({cur_addr, 1'b1}, a); rbyte(1'b1, h); bus_stop();
      chk("R6 cfg readback", h, {1'b1, c[6:0]});
    end
    @(posedge clk); #1 os_flag = 1'b0; os_upd = 1'b1;
    @(posedge clk); #1 os_upd = 1'b0;
    bus_start(); wbyte({cur_addr, 1'b1}, a); rbyte(1'b1, h); bus_stop();
    chk("R6 status flag loaded", h[7], 0);

    // R7 temperature sweep, R3 temperature not writable
    set_ptr(2'b00);
    for (int i = 0; i < 16; i++) begin
      v = 12'((i * 273 + 5) & 12'hFFF);
      @(posedge clk); #1 temp_in = v; temp_vld = 1'b1;
      @(posedge clk); #1 temp_vld = 1'b0; temp_in = ~v;
      rd_word(h, l); chk("R7 temp loaded", {h, l}, {v, 4'h0});
    end
    wr_word(2'b00, 8'hAA, 8'hBB);
    rd_word(h, l); chk("R3 temp write ignored", {h, l}, {v, 4'h0});

    // R10 master NACK releases SDA
    bus_start(); wbyte({cur_addr, 1'b1}, a); rbyte(1'b1, h);
    qw(); qw();
    chk("R10 released after NACK", sda_oe, 0);
    bus_stop();

    // R2 wrong address and pin change
    bus_start(); wbyte(8'hA4, a); bus_stop(); chk("R2 other address nack", a, 0);
    pins = 3'b101;
    bus_start(); wbyte({4'b1001, 3'b101, 1'b0}, a); bus_stop();
    chk("R2 pins not resampled", a, 0);
    // R8 relatch only
    set_ptr(2'b10);
    wr_word(2'b10, 8'h12, 8'h30);
    bus_start(); wbyte(8'h00, a); chk("R8 gc ack", a, 1);
    wbyte(8'h04, a); chk("R8 relatch ack", a, 1); bus_stop();
    bus_start(); wbyte({4'b1001, 3'b010, 1'b0}, a); bus_stop();
    chk("R8 old address dropped", a, 0);
    cur_addr = {4'b1001, 3'b101};
    chk("R8 relatch keeps tlow", tlow, 12'h123);
    rd_word(h, l); chk("R8 new address works", {h, l}, 16'h1230);
    // R8 reset command
    bus_start(); wbyte(8'h00, a); wbyte(8'h06, a); chk("R8 reset ack", a, 1); bus_stop();
    chk("R8 tlow reset", tlow, 12'h4B0);
    chk("R8 thigh reset", thigh, 12'h500);
    chk("R8 cfg reset", cfg, 0);
    rd_word(h, l); chk("R8 pointer and temp reset", {h, l}, 16'h0000);

    // R9 high-speed master code
    bus_start(); wbyte(8'h0B, a);
    chk("R9 code not acked", a, 0);
    chk("R9 hs flag set", hs_mode, 1);
    bus_start(); wbyte({cur_addr, 1'b0}, a); wbyte(8'h03, a);
    chk("R9 flag kept over repeated start", hs_mode, 1);
    bus_stop(); qw();
    chk("R9 flag cleared by stop", hs_mode, 0);

    // R11 aborts mid-byte
    bus_start();
    for (int i = 0; i < 4; i++) bus_bit(1'b1, a);
    bus_stop(); qw();
    chk("R11 stop mid-byte releases", sda_oe, 0);
    bus_start();
    for (int i = 0; i < 3; i++) bus_bit(1'b0, a);
    bus_start(); wbyte({cur_addr, 1'b1}, a);
    chk("R11 restart after partial byte", a, 1);
    rbyte(1'b0, h); rbyte(1'b1, l); bus_stop();
    chk("R11 data after restart", {h, l}, 16'h5000);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule